// File: doc/BRIEF.md
# DMA Request and Shared Interrupt Input

This block takes one external pin and steers it to one of two consumers. When its DMA channel is enabled and set for external synchronization, the pin is a level-sensitive DMA request. It passes through a two-flop synchronizer and is forwarded without latching. Otherwise the pin is an extra maskable interrupt source. A rising edge on the synchronized pin sets a pending bit, and that bit stays set until the interrupt controller acknowledges it.

The interrupt reuses the DMA channel's interrupt type code. The code is 0x0A for channel 0 and 0x0B for channel 1, chosen by a parameter. One mask bit gates the request output but does not stop the pending bit from being set.

Top module: `dreq_irq_steer`

## Requirements
- R1: In DMA mode (`chan_en`=1 and `ext_sync`=1), `dma_req` goes high after the second rising clock edge following a rise of `pin_raw`.
- R2: `dma_req` is not latched. It goes low after the second rising edge following a fall of `pin_raw`, with no acknowledge needed.
- R3: When `chan_en`=0 or `ext_sync`=0 the block is in interrupt mode, and `dma_req` stays 0 whatever `pin_raw` does.
- R4: In interrupt mode, a 0-to-1 transition of `pin_raw` sets the pending bit at the third rising edge after the transition. A pin held high makes no further requests.
- R5: The pending bit stays set until a clock edge with `irq_ack`=1 clears it. If a new edge is detected at the same clock edge as the acknowledge, the bit stays set.
- R6: While `irq_mask`=1, `irq_req` is 0 but edges still set the pending bit. Clearing the mask then raises `irq_req` in the same cycle.
- R7: `irq_type` is 8'h0A when parameter CHAN=0 and 8'h0B when CHAN=1.
- R8: In DMA mode the pending bit is cleared at each clock edge and `irq_req` is 0.
- R9: While `rst_n`=0 and after its release, `dma_req` and `irq_req` are 0 until the pin acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_raw | input | 1 | Raw asynchronous pin |
| chan_en | input | 1 | DMA channel enabled |
| ext_sync | input | 1 | DMA channel uses external synchronization |
| irq_mask | input | 1 | Interrupt mask bit, 1 masks |
| irq_ack | input | 1 | Acknowledge pulse for this channel's interrupt type |
| dma_req | output | 1 | Synchronized level DMA request |
| irq_req | output | 1 | Pending, unmasked interrupt request |
| irq_type | output | 8 | Interrupt type code of the channel |

## Verification
The assertions assume that `chan_en`, `ext_sync` and `irq_mask` are quasi-static register bits that change only between clock edges. They also assume that `irq_ack` is a synchronous one-cycle pulse. The bench drives every input half a period away from the rising edge. Within one sweep run it holds the mode bits constant, and it changes them only in the directed mode-switch and unmask cases. Acknowledges are single-cycle pulses at fixed intervals. Some of them land on a detected edge, which exercises the set-wins case.

// File: rtl/dreq_irq_steer.sv
module dreq_irq_steer #(
  parameter int CHAN   = 0,
  parameter int TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_raw,
  input  logic              chan_en,
  input  logic              ext_sync,
  input  logic              irq_mask,
  input  logic              irq_ack,
  output logic              dma_req,
  output logic              irq_req,
  output logic [TYPE_W-1:0] irq_type
);

  localparam logic [TYPE_W-1:0] TYPE_CODE = (CHAN == 0) ? TYPE_W'(8'h0A) : TYPE_W'(8'h0B);

  logic meta_q, sync_q, prev_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  wire dma_mode = chan_en & ext_sync;
  wire rise     = sync_q & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (dma_mode) pend_q <= 1'b0;
    else               pend_q <= (pend_q & ~irq_ack) | rise;
  end

  assign dma_req  = dma_mode & sync_q;
  assign irq_req  = pend_q & ~irq_mask;
  assign irq_type = TYPE_CODE;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  p_dma_follows_pin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && dma_mode) |-> (dma_req == $past(pin_raw, 2)));

  p_dma_unlatched_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && dma_mode && !$past(pin_raw, 2)) |-> !dma_req);

  p_dma_quiet_irqmode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_mode |-> !dma_req);

  p_pend_needs_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !rise) |=> !pend_q);

  p_pend_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !irq_ack && !dma_mode) |=> pend_q);

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && irq_ack && !rise) |=> !pend_q);

  p_mask_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq_req);

  p_dma_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_mode |=> !pend_q);

endmodule

// File: tb/dreq_irq_steer_bench.sv
module dreq_irq_steer_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, pin_raw, chan_en, ext_sync, irq_mask, irq_ack;
  logic dma_req, irq_req, dma_req0, irq_req0;
  logic [7:0] irq_type, irq_type0;

  dreq_irq_steer #(.CHAN(1)) u_dreq_irq_steer (
    .clk, .rst_n, .pin_raw, .chan_en, .ext_sync, .irq_mask, .irq_ack,
    .dma_req, .irq_req, .irq_type);

  dreq_irq_steer #(.CHAN(0)) u_ch0 (
    .clk, .rst_n, .pin_raw(1'b0), .chan_en(1'b0), .ext_sync(1'b0),
    .irq_mask(1'b0), .irq_ack(1'b0),
    .dma_req(dma_req0), .irq_req(irq_req0), .irq_type(irq_type0));

  int compared = 0, mismatched = 0;
  localparam int N = 120;
  logic hist [0:N-1];
  logic ackv [0:N-1];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_raw = 1'b0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic h(input int i);
    return (i < 0) ? 1'b0 : hist[i];
  endfunction

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    chan_en = 1'b0; ext_sync = 1'b0; irq_mask = 1'b0;
    rst_n = 1'b0; pin_raw = 1'b0; irq_ack = 1'b0;
    @(negedge clk);
    chk("R9 dma_req in reset", {7'd0, dma_req}, 8'd0);
    chk("R9 irq_req in reset", {7'd0, irq_req}, 8'd0);
    chk("R7 type ch1", irq_type, 8'h0B);
    chk("R7 type ch0", irq_type0, 8'h0A);

    for (int cfg = 0; cfg < 8; cfg++) begin
      logic dm, pend, sync_v, edg;
      chan_en = cfg[0]; ext_sync = cfg[1]; irq_mask = cfg[2];
      dm = chan_en & ext_sync;
      for (int i = 0; i < N; i++) begin
        hist[i] = (((i / 3) ^ (i / 7) ^ cfg) & 1) != 0;
        ackv[i] = (i % 9) == 4;
      end
      do_reset();
      pend = 1'b0;
      for (int n = 0; n < N; n++) begin
        if (n > 0) begin
          sync_v = h(n - 2);
          chk(dm ? "R1 R2 dma level" : "R3 dma low in irq mode",
              {7'd0, dma_req}, {7'd0, dm & sync_v});
          chk(dm ? "R8 no irq in dma mode" : (irq_mask ? "R6 masked" : "R4 R5 irq pending"),
              {7'd0, irq_req}, {7'd0, pend & ~irq_mask});
        end else begin
          chk("R9 after release", {6'd0, dma_req, irq_req}, 8'd0);
        end
        pin_raw = hist[n]; irq_ack = ackv[n];
        @(posedge clk);
        edg = h(n - 2) & ~h(n - 3);
        pend = dm ? 1'b0 : ((pend & ~ackv[n]) | edg);
        @(negedge clk);
      end
    end

    chan_en = 1'b0; ext_sync = 1'b1; irq_mask = 1'b1;
    do_reset();
    pin_raw = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 masked no req", {7'd0, irq_req}, 8'd0);
    irq_mask = 1'b0; #1;
    chk("R6 unmask shows pending", {7'd0, irq_req}, 8'd1);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R5 ack clears", {7'd0, irq_req}, 8'd0);
    repeat (5) @(negedge clk);
    chk("R4 held high no retrigger", {7'd0, irq_req}, 8'd0);
    pin_raw = 1'b0; repeat (3) @(negedge clk);
    pin_raw = 1'b1; repeat (2) @(negedge clk);
    chk("R4 two edges after rise not yet", {7'd0, irq_req}, 8'd0);
    @(negedge clk);
    chk("R4 three edges after rise", {7'd0, irq_req}, 8'd1);
    chan_en = 1'b1; @(negedge clk);
    chk("R8 dma mode clears pending", {7'd0, irq_req}, 8'd0);
    chk("R1 dma_req with pin high", {7'd0, dma_req}, 8'd1);
    chan_en = 1'b0; @(negedge clk);
    chk("R8 pending stays cleared", {7'd0, irq_req}, 8'd0);
    chk("R3 dma_req low after leaving dma mode", {7'd0, dma_req}, 8'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule